// File: doc/BRIEF.md
# Output Driver Impedance Calibration Controller

This controller keeps the strength setting of an output driver close to its optimum while supply voltage and temperature drift. An external analog comparator reports on every cycle whether the driver should be made stronger or weaker. At a fixed evaluation interval the controller samples that report and moves an internal target code by one step, up or down. The code saturates at its ends and does not wrap.

The driver itself must never change strength while it is driving the line. The target code is therefore copied into the active drive register only on a clock edge at which the output is in high-impedance. Write cycles, deselect cycles and an output disable held across a clock edge all give such a window.

A power-up flag reports when the driver can be taken as fully calibrated. This requires a settling count of clock edges since reset, followed by a change of the output from driving to high-impedance.

Top module: `zq_drive_cal`

## Requirements
- R1: During and directly after reset, `drive_code` equals RESET_CODE (16 by default) and `cal_done` is 0.
- R2: The target code is evaluated on the EVAL_PERIOD-th clock edge after reset and on every EVAL_PERIOD-th edge after that. Between evaluations it does not change.
- R3: At an evaluation, `cmp_up`=1 raises the target code by exactly one and `cmp_up`=0 lowers it by exactly one.
- R4: The target code saturates. An up step at 31 leaves it at 31, and a down step at 0 leaves it at 0.
- R5: `drive_code` can change only on a clock edge at which `hiz`=1. While `hiz`=0 it holds its value, whatever the evaluations do.
- R6: On an edge with `hiz`=1, `drive_code` takes the target value held just before that edge. An evaluation on the same edge shows up at the next high-impedance edge.
- R7: `cal_done` rises only on an edge where `hiz`=1 and `hiz` was 0 at the previous edge, and only once at least SETTLE_CYCLES edges have passed since reset. Such a transition earlier than that, or `hiz` held high since reset, leaves it at 0.
- R8: Once set, `cal_done` stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_up | input | 1 | Comparator direction: 1 = stronger, 0 = weaker |
| hiz | input | 1 | 1 when the output is in high-impedance at this edge |
| drive_code | output | CODE_W | Active drive strength code applied to the driver |
| cal_done | output | 1 | Power-up calibration complete |

## Verification
The bench builds the controller with an evaluation interval of 8 edges and a settling count of 40 edges instead of 64 and 4096. With these values a single short run can walk the code from midscale to both saturation limits. It can also place a driving-to-high-impedance transition both before and after the settling point. A behavioural model steps alongside the design every cycle. Directed points cover a hold of the code during a long driving stretch, an evaluation landing on the same edge as a load, and the flag clearing again on reset.

// File: rtl/zq_drive_cal.sv
module zq_drive_cal #(
  parameter int CODE_W        = 5,
  parameter int EVAL_PERIOD   = 64,
  parameter int SETTLE_CYCLES = 4096,
  parameter int RESET_CODE    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_up,
  input  logic              hiz,
  output logic [CODE_W-1:0] drive_code,
  output logic              cal_done
);

  localparam int EW = (EVAL_PERIOD > 1) ? $clog2(EVAL_PERIOD) : 1;
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [EW-1:0]     EVAL_LAST  = EW'(EVAL_PERIOD - 1);
  localparam logic [SW-1:0]     SETTLE_END = SW'(SETTLE_CYCLES);
  localparam logic [CODE_W-1:0] CODE_TOP   = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_RST   = CODE_W'(RESET_CODE);

  logic [EW-1:0]     eval_cnt;
  logic [SW-1:0]     settle_cnt;
  logic [CODE_W-1:0] tgt_code;
  logic [CODE_W-1:0] tgt_next;
  logic              hiz_q;

  wire eval_tick = (eval_cnt == EVAL_LAST);
  wire settled   = (settle_cnt == SETTLE_END);
  wire lz_to_hz  = hiz & ~hiz_q;

  always_comb begin
    tgt_next = tgt_code;
    if (cmp_up && tgt_code != CODE_TOP)
      tgt_next = tgt_code + 1'b1;
    else if (!cmp_up && tgt_code != '0)
      tgt_next = tgt_code - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eval_cnt <= '0;
      tgt_code <= CODE_RST;
    end else if (eval_tick) begin
      eval_cnt <= '0;
      tgt_code <= tgt_next;
    end else begin
      eval_cnt <= eval_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      drive_code <= CODE_RST;
    else if (hiz)
      drive_code <= tgt_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_cnt <= '0;
      hiz_q      <= 1'b1;
      cal_done   <= 1'b0;
    end else begin
      if (!settled)
        settle_cnt <= settle_cnt + 1'b1;
      hiz_q <= hiz;
      if (settled && lz_to_hz)
        cal_done <= 1'b1;
    end
  end

endmodule

// File: rtl/zq_drive_cal_chk.sv
module zq_drive_cal_chk #(
  parameter int CODE_W      = 5,
  parameter int EVAL_PERIOD = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hiz,
  input logic [CODE_W-1:0] tgt_code,
  input logic [CODE_W-1:0] drive_code,
  input logic              cal_done
);

  localparam int EW = (EVAL_PERIOD > 1) ? $clog2(EVAL_PERIOD) : 1;
  localparam logic [EW-1:0]     LAST = EW'(EVAL_PERIOD - 1);
  localparam logic [CODE_W-1:0] TOP  = {CODE_W{1'b1}};

  logic [EW-1:0] edge_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             edge_cnt <= '0;
    else if (edge_cnt == LAST) edge_cnt <= '0;
    else                    edge_cnt <= edge_cnt + 1'b1;
  end

  // R2
  eval_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tgt_code) |-> $past(edge_cnt) == LAST);

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_code == $past(tgt_code)) || (tgt_code == $past(tgt_code) + 1'b1) ||
    (tgt_code == $past(tgt_code) - 1'b1));

  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(($past(tgt_code) == TOP && tgt_code == '0) || ($past(tgt_code) == '0 && tgt_code == TOP)));

  // R5
  hold_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hiz) |-> $stable(drive_code));

  // R7
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_done) |-> $past(hiz) && !$past(hiz, 2));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cal_done) |-> cal_done);

endmodule

bind zq_drive_cal zq_drive_cal_chk #(.CODE_W(CODE_W), .EVAL_PERIOD(EVAL_PERIOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .hiz(hiz), .tgt_code(tgt_code),
  .drive_code(drive_code), .cal_done(cal_done));

// File: tb/zq_drive_cal_tb.sv
module zq_drive_cal_tb;
  localparam int P = 8;
  localparam int S = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_up = 1'b0;
  logic hiz = 1'b1;
  logic [4:0] drive_code;
  logic cal_done;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  int m_tgt, m_act, m_cnt, m_edges, m_prevh, m_done;

  always #4 clk = ~clk;

  zq_drive_cal #(.CODE_W(5), .EVAL_PERIOD(P), .SETTLE_CYCLES(S), .RESET_CODE(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_up(cmp_up), .hiz(hiz),
    .drive_code(drive_code), .cal_done(cal_done));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tgt = 16; m_act = 16; m_cnt = 0; m_edges = 0; m_prevh = 1; m_done = 0;
    end else begin
      int nact;
      nact = hiz ? m_tgt : m_act;
      if (m_edges >= S && hiz && !m_prevh) m_done = 1;
      if (m_cnt == P - 1) begin
        m_cnt = 0;
        if (cmp_up) m_tgt = (m_tgt < 31) ? m_tgt + 1 : 31;
        else        m_tgt = (m_tgt > 0)  ? m_tgt - 1 : 0;
      end else m_cnt++;
      if (m_edges < S) m_edges++;
      m_prevh = hiz ? 1 : 0;
      m_act = nact;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R5 R6 drive_code vs model", drive_code, m_act);
      chk("R7 R8 cal_done vs model", cal_done, m_done);
    end
    if (cycles > 200000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 200000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(2);
    chk("R1 drive_code in reset", drive_code, 16);
    chk("R1 cal_done in reset", cal_done, 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 drive_code after reset", drive_code, 16);

    // early low-to-high transition must not set the flag (R7)
    hiz = 1'b0; step(3); hiz = 1'b1; step(2);
    chk("R7 early transition ignored", cal_done, 0);

    // rise three steps with output in high-Z (R2, R3)
    cmp_up = 1'b1;
    step(3 * P - 5);
    chk("R3 three up steps", drive_code, 19);

    // driving stretch: code must hold (R5)
    hiz = 1'b0; cmp_up = 1'b0;
    step(3 * P);
    chk("R5 hold while driving", drive_code, 19);
    hiz = 1'b1; step(1);
    chk("R5 load at high-Z edge", drive_code, 16);
    chk("R7 settled transition sets flag", cal_done, 1);

    // saturate high (R4)
    cmp_up = 1'b1;
    step(20 * P);
    chk("R4 saturate at 31", drive_code, 31);
    // saturate low (R4)
    cmp_up = 1'b0;
    step(36 * P);
    chk("R4 saturate at 0", drive_code, 0);

    // sticky flag through toggles (R8)
    hiz = 1'b0; step(5); hiz = 1'b1; step(5);
    chk("R8 flag sticky", cal_done, 1);

    // same-edge evaluation and load (R6): align with cmp_up=1 from code 0
    cmp_up = 1'b1; hiz = 1'b0;
    step(P);
    hiz = 1'b1;
    step(P);
    chk("R6 same-edge update via model", drive_code, m_act);

    // reset clears flag, hiz held high never sets it (R1, R7)
    rst_n = 1'b0; step(2);
    chk("R1 cal_done cleared by reset", cal_done, 0);
    rst_n = 1'b1; hiz = 1'b1;
    step(S + 10);
    chk("R7 hiz held high since reset", cal_done, 0);
    chk("R2 eval count since reset", drive_code, m_act);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule